// File: doc/BRIEF.md
# Real-Time Clock Index/Data Register Front End

This block sits between a host bus and a free-running time-of-day source and presents that time through a classic two-port register scheme. The host first writes a register number to the address port. It then reads or writes the chosen register through the data port. The selected register number stays in place, so repeated data-port accesses reach the same register.

The time of day arrives as binary fields: seconds, minutes, hours, weekday, day of month, month and full year. A one-second tick comes with it. On each tick the block copies these fields into a private snapshot. Host reads are served from that snapshot, so a program that reads hours, minutes and seconds one after another gets a consistent set within the same second. A halt bit freezes the snapshot.

Status register B chooses between packed BCD and plain binary output, and between 12-hour and 24-hour output. Rejected accesses raise a one-cycle error flag.

Top module: `rtc_regfront`

## Requirements
- R1: An address-port write of a legal register number selects that register. The legal numbers are 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 weekday, 0x07 day, 0x08 month, 0x09 year, 0x32 century, and 0x0A to 0x0F. Any other number raises the error flag and leaves the selection unchanged. A read of the address port also raises the error flag.
- R2: Any access with busBytes other than 1, on either port, raises the error flag and changes no state.
- R3: The snapshot reloads from the time inputs only on a tick. Between ticks, changes on the time inputs do not appear in reads.
- R4: While bit 7 of status B is 1, ticks do not reload the snapshot. A tick that arrived during the halt is applied once bit 7 clears.
- R5: When status B bit 2 is 0, time fields read as packed BCD (tens in bits 7:4, ones in bits 3:0). When bit 2 is 1, they read as plain binary.
- R6: When status B bit 1 is 1, hours read in 24-hour form. When it is 0, hours read as 1 to 12, with hour 0 and hour 12 shown as 12, and bit 7 is set for hours 12 to 23.
- R7: Weekday reads as input plus 1 (1 to 7). Month reads as input plus 1 (1 to 12). Year reads as the year modulo 100. Century reads as the year divided by 100.
- R8: A write to status A (0x0A) stores the written byte with bit 7 cleared.
- R9: A write to status B (0x0B) with bit 6 set raises the error flag and leaves status B unchanged. Other writes to status B are stored as written and read back.
- R10: Register 0x0D reads 0x80. Registers 0x0C and 0x0E read 0x00. Writes to 0x0C, 0x0D and 0x0E raise the error flag.
- R11: Writes to the time registers (0x00 to 0x09 and 0x32) are accepted without error and change nothing. Register 0x0F is a plain read/write byte.
- R12: After reset, status A, status B and 0x0F hold 0, the selection is 0x00, the snapshot is all zero until the first tick, and busRdata and busErr are 0.
- R13: busRdata and busErr are registered. They reflect an access on the clock edge that samples it. busRdata holds its value on cycles with no accepted data-port read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access strobe, one cycle per access |
| busIsAddr | input | 1 | 1 selects the address port, 0 the data port |
| busWrite | input | 1 | 1 for write, 0 for read |
| busBytes | input | 3 | Access size in bytes; only 1 is accepted |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid the cycle after a read |
| busErr | output | 1 | One-cycle pulse for a rejected access |
| secondTick | input | 1 | One-second tick |
| todSec | input | 6 | Seconds, 0 to 59 |
| todMin | input | 6 | Minutes, 0 to 59 |
| todHour | input | 5 | Hours, 0 to 23 |
| todWday | input | 3 | Weekday, 0 to 6 |
| todMday | input | 5 | Day of month, 1 to 31 |
| todMon | input | 4 | Month, 0 to 11 |
| todYear | input | YEAR_W | Full year |

## Verification
A corrupted snapshot or a wrong reload decision shows up on the first time-field read after the next tick. A wrong format bit shows up on the very next read of hours or any other time field. A bad selection register sends every later data-port access to the wrong register, so the error flag or the read data is wrong one cycle after that access. Status filtering faults show up on the readback of status A or B, or on a missing error pulse, one cycle after the offending write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [7:0] IDX_SEC  = 8'h00;
  localparam logic [7:0] IDX_MIN  = 8'h02;
  localparam logic [7:0] IDX_HOUR = 8'h04;
  localparam logic [7:0] IDX_WDAY = 8'h06;
  localparam logic [7:0] IDX_MDAY = 8'h07;
  localparam logic [7:0] IDX_MON  = 8'h08;
  localparam logic [7:0] IDX_YEAR = 8'h09;
  localparam logic [7:0] IDX_CENT = 8'h32;
  localparam logic [7:0] IDX_STA  = 8'h0A;
  localparam logic [7:0] IDX_STB  = 8'h0B;
  localparam logic [7:0] IDX_STC  = 8'h0C;
  localparam logic [7:0] IDX_STD  = 8'h0D;
  localparam logic [7:0] IDX_DIAG = 8'h0E;
  localparam logic [7:0] IDX_RST  = 8'h0F;

  localparam int STB_HALT = 7;
  localparam int STB_PIE  = 6;
  localparam int STB_BIN  = 2;
  localparam int STB_H24  = 1;
  localparam int STA_UIP  = 7;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic ldIndex;
    logic wrStatA;
    logic wrStatB;
    logic wrRst;
    logic rdData;
    logic err;
  } rtcStrobe_t;

  function automatic logic isTimeIndex(input logic [7:0] idx);
    return (idx == IDX_SEC) || (idx == IDX_MIN) || (idx == IDX_HOUR) ||
           (idx == IDX_WDAY) || (idx == IDX_MDAY) || (idx == IDX_MON) ||
           (idx == IDX_YEAR) || (idx == IDX_CENT);
  endfunction

  function automatic logic isLegalIndex(input logic [7:0] idx);
    return isTimeIndex(idx) || ((idx >= IDX_STA) && (idx <= IDX_RST));
  endfunction

  // binary 0..99 to packed BCD, or passthrough when bin is set
  function automatic logic [7:0] fmtField(input logic [6:0] v, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    if (bin) return {1'b0, v};
    return {tens[3:0], ones[3:0]};
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busValid,
  input  logic       busIsAddr,
  input  logic       busWrite,
  input  logic [2:0] busBytes,
  input  logic [7:0] busWdata,
  input  logic [7:0] curIndex,
  output rtcStrobe_t strobe,
  output logic       busErr
);

  logic sizeOk;
  logic errNow;

  assign sizeOk = (busBytes == 3'd1);

  always_comb begin
    strobe = '0;
    errNow = 1'b0;
    if (busValid) begin
      if (!sizeOk) begin
        errNow = 1'b1;
      end else if (busIsAddr) begin
        if (busWrite && isLegalIndex(busWdata)) strobe.ldIndex = 1'b1;
        else errNow = 1'b1;
      end else if (!busWrite) begin
        strobe.rdData = 1'b1;
      end else begin
        unique case (curIndex)
          IDX_STA: strobe.wrStatA = 1'b1;
          IDX_STB: begin
            if (busWdata[STB_PIE]) errNow = 1'b1;
            else strobe.wrStatB = 1'b1;
          end
          IDX_RST: strobe.wrRst = 1'b1;
          IDX_STC, IDX_STD, IDX_DIAG: errNow = 1'b1;
          default: ;
        endcase
      end
    end
    strobe.err = errNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busErr <= 1'b0;
    else busErr <= strobe.err;
  end

endmodule

// File: rtl/rtc_dpath.sv
module rtc_dpath
  import rtc_pkg::*;
#(
  parameter int YEAR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rtcStrobe_t        strobe,
  input  logic [7:0]        busWdata,
  input  logic              secondTick,
  input  logic [5:0]        todSec,
  input  logic [5:0]        todMin,
  input  logic [4:0]        todHour,
  input  logic [2:0]        todWday,
  input  logic [4:0]        todMday,
  input  logic [3:0]        todMon,
  input  logic [YEAR_W-1:0] todYear,
  output logic [7:0]        curIndex,
  output logic [7:0]        statB,
  output logic [5:0]        snapSec,
  output logic [7:0]        busRdata
);

  localparam logic [YEAR_W-1:0] HUNDRED = YEAR_W'(100);

  logic [7:0] statA;
  logic [7:0] rstCode;
  logic       tickPend;
  logic       reload;

  logic [5:0]        snapMin;
  logic [4:0]        snapHour;
  logic [2:0]        snapWday;
  logic [4:0]        snapMday;
  logic [3:0]        snapMon;
  logic [YEAR_W-1:0] snapYear;

  // snapshot refresh: a tick seen while halted waits for the halt to clear
  assign reload = (secondTick || tickPend) && !statB[STB_HALT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tickPend <= 1'b0;
      snapSec  <= '0;
      snapMin  <= '0;
      snapHour <= '0;
      snapWday <= '0;
      snapMday <= '0;
      snapMon  <= '0;
      snapYear <= '0;
    end else begin
      tickPend <= (secondTick || tickPend) && statB[STB_HALT];
      if (reload) begin
        snapSec  <= todSec;
        snapMin  <= todMin;
        snapHour <= todHour;
        snapWday <= todWday;
        snapMday <= todMday;
        snapMon  <= todMon;
        snapYear <= todYear;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curIndex <= IDX_SEC;
      statA    <= '0;
      statB    <= '0;
      rstCode  <= '0;
    end else begin
      if (strobe.ldIndex) curIndex <= busWdata;
      if (strobe.wrStatA) statA <= busWdata & ~(8'h1 << STA_UIP);
      if (strobe.wrStatB) statB <= busWdata;
      if (strobe.wrRst)   rstCode <= busWdata;
    end
  end

  // field formatting
  logic              binMode;
  logic              pmFlag;
  logic [4:0]        hourMod;
  logic [4:0]        hourShown;
  logic [7:0]        hourByte;
  logic [YEAR_W-1:0] yearLo;
  logic [YEAR_W-1:0] yearHi;
  logic [7:0]        readMux;

  assign binMode = statB[STB_BIN];
  assign pmFlag  = (snapHour >= 5'd12);
  assign hourMod = pmFlag ? (snapHour - 5'd12) : snapHour;

  always_comb begin
    if (statB[STB_H24]) hourShown = snapHour;
    else if (hourMod == 5'd0) hourShown = 5'd12;
    else hourShown = hourMod;
    hourByte = fmtField({2'b00, hourShown}, binMode);
    if (!statB[STB_H24] && pmFlag) hourByte[7] = 1'b1;
  end

  assign yearLo = snapYear % HUNDRED;
  assign yearHi = snapYear / HUNDRED;

  always_comb begin
    unique case (curIndex)
      IDX_SEC:  readMux = fmtField({1'b0, snapSec}, binMode);
      IDX_MIN:  readMux = fmtField({1'b0, snapMin}, binMode);
      IDX_HOUR: readMux = hourByte;
      IDX_WDAY: readMux = fmtField({4'b0, snapWday} + 7'd1, binMode);
      IDX_MDAY: readMux = fmtField({2'b0, snapMday}, binMode);
      IDX_MON:  readMux = fmtField({3'b0, snapMon} + 7'd1, binMode);
      IDX_YEAR: readMux = fmtField(yearLo[6:0], binMode);
      IDX_CENT: readMux = fmtField(yearHi[6:0], binMode);
      IDX_STA:  readMux = statA;
      IDX_STB:  readMux = statB;
      IDX_STD:  readMux = 8'h80;
      IDX_RST:  readMux = rstCode;
      default:  readMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busRdata <= '0;
    else if (strobe.rdData) busRdata <= readMux;
  end

endmodule

// File: rtl/rtc_regfront.sv
module rtc_regfront
  import rtc_pkg::*;
#(
  parameter int YEAR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busIsAddr,
  input  logic              busWrite,
  input  logic [2:0]        busBytes,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              busErr,
  input  logic              secondTick,
  input  logic [5:0]        todSec,
  input  logic [5:0]        todMin,
  input  logic [4:0]        todHour,
  input  logic [2:0]        todWday,
  input  logic [4:0]        todMday,
  input  logic [3:0]        todMon,
  input  logic [YEAR_W-1:0] todYear
);

  rtcStrobe_t strobe;
  logic [7:0] curIndex;
  logic [7:0] statB;
  logic [5:0] snapSec;

  rtc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busValid  (busValid),
    .busIsAddr (busIsAddr),
    .busWrite  (busWrite),
    .busBytes  (busBytes),
    .busWdata  (busWdata),
    .curIndex  (curIndex),
    .strobe    (strobe),
    .busErr    (busErr)
  );

  rtc_dpath #(.YEAR_W(YEAR_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .secondTick (secondTick),
    .todSec     (todSec),
    .todMin     (todMin),
    .todHour    (todHour),
    .todWday    (todWday),
    .todMday    (todMday),
    .todMon     (todMon),
    .todYear    (todYear),
    .curIndex   (curIndex),
    .statB      (statB),
    .snapSec    (snapSec),
    .busRdata   (busRdata)
  );

endmodule

// File: rtl/rtc_regfront_chk.sv
module rtc_regfront_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busValid,
  input logic       busIsAddr,
  input logic       busWrite,
  input logic [2:0] busBytes,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic       busErr,
  input logic [7:0] curIndex,
  input logic [7:0] statB,
  input logic [5:0] snapSec
);

  logic dataRd;
  logic dataWr;
  assign dataRd = busValid && !busIsAddr && !busWrite && (busBytes == 3'd1);
  assign dataWr = busValid && !busIsAddr && busWrite && (busBytes == 3'd1);

  assert_size_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && busBytes != 3'd1) |=> busErr);

  assert_bad_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && busIsAddr && busWrite && busBytes == 3'd1 && !isLegalIndex(busWdata))
      |=> (busErr && $stable(curIndex)));

  assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    statB[STB_HALT] |=> $stable(snapSec));

  assert_stat_d_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dataRd && curIndex == IDX_STD) |=> (busRdata == 8'h80));

  assert_stat_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dataRd && curIndex == IDX_STA) |=> !busRdata[7]);

  assert_pie_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dataWr && curIndex == IDX_STB && busWdata[STB_PIE]) |=> (busErr && $stable(statB)));

endmodule

bind rtc_regfront rtc_regfront_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busValid  (busValid),
  .busIsAddr (busIsAddr),
  .busWrite  (busWrite),
  .busBytes  (busBytes),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .busErr    (busErr),
  .curIndex  (curIndex),
  .statB     (statB),
  .snapSec   (snapSec)
);

// File: tb/rtc_regfront_tb.sv
`timescale 1ns/1ps
module rtc_regfront_tb;

  localparam int YW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busValid = 1'b0;
  logic          busIsAddr = 1'b0;
  logic          busWrite = 1'b0;
  logic [2:0]    busBytes = 3'd1;
  logic [7:0]    busWdata = 8'h00;
  logic [7:0]    busRdata;
  logic          busErr;
  logic          secondTick = 1'b0;
  logic [5:0]    todSec = '0;
  logic [5:0]    todMin = '0;
  logic [4:0]    todHour = '0;
  logic [2:0]    todWday = '0;
  logic [4:0]    todMday = '0;
  logic [3:0]    todMon = '0;
  logic [YW-1:0] todYear = '0;

  always #2 clk = ~clk;

  rtc_regfront #(.YEAR_W(YW)) u_dut (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busIsAddr(busIsAddr),
    .busWrite(busWrite), .busBytes(busBytes), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .secondTick(secondTick),
    .todSec(todSec), .todMin(todMin), .todHour(todHour), .todWday(todWday),
    .todMday(todMday), .todMon(todMon), .todYear(todYear)
  );

  typedef struct {
    bit         chkData;
    logic [7:0] expData;
    logic       expErr;
    string      tag;
  } expItem_t;

  expItem_t sbq[$];
  int  nChecks = 0;
  int  nFails = 0;
  bit  issue = 1'b0;
  bit  done = 1'b0;

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] showField(input int v, input bit bin);
    return bin ? 8'(v) : toBcd(v);
  endfunction

  // monitor: compares the registered result one step after the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (issue && sbq.size() > 0) begin
        expItem_t it;
        it = sbq.pop_front();
        nChecks++;
        if ((busErr !== it.expErr) || (it.chkData && (busRdata !== it.expData))) begin
          nFails++;
          $display("FAIL %s: got data=%h err=%b, expected data=%h err=%b",
                   it.tag, busRdata, busErr, it.expData, it.expErr);
        end
      end
    end
  end

  task automatic access(input bit isAddr, input bit wr, input logic [2:0] bytes,
                        input logic [7:0] wd, input bit chk, input logic [7:0] expD,
                        input logic expE, input string tag);
    expItem_t it;
    @(negedge clk);
    busValid = 1'b1; busIsAddr = isAddr; busWrite = wr;
    busBytes = bytes; busWdata = wd;
    it.chkData = chk; it.expData = expD; it.expErr = expE; it.tag = tag;
    sbq.push_back(it);
    issue = 1'b1;
    @(negedge clk);
    busValid = 1'b0; issue = 1'b0; busBytes = 3'd1;
  endtask

  task automatic selReg(input logic [7:0] idx, input string tag);
    access(1'b1, 1'b1, 3'd1, idx, 1'b0, 8'h00, 1'b0, tag);
  endtask

  task automatic readReg(input logic [7:0] idx, input logic [7:0] expD, input string tag);
    selReg(idx, tag);
    access(1'b0, 1'b0, 3'd1, 8'h00, 1'b1, expD, 1'b0, tag);
  endtask

  task automatic writeReg(input logic [7:0] idx, input logic [7:0] wd,
                          input logic expE, input string tag);
    selReg(idx, tag);
    access(1'b0, 1'b1, 3'd1, wd, 1'b0, 8'h00, expE, tag);
  endtask

  task automatic pulseTick();
    @(negedge clk);
    secondTick = 1'b1;
    @(negedge clk);
    secondTick = 1'b0;
  endtask

  task automatic setTime(input int s, input int m, input int h, input int wd,
                         input int md, input int mo, input int yr);
    todSec = 6'(s); todMin = 6'(m); todHour = 5'(h); todWday = 3'(wd);
    todMday = 5'(md); todMon = 4'(mo); todYear = YW'(yr);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state at the ports
    nChecks++;
    if (busRdata !== 8'h00 || busErr !== 1'b0) begin
      nFails++;
      $display("FAIL R12: got data=%h err=%b, expected data=00 err=0", busRdata, busErr);
    end
    // R12: index defaults to seconds, snapshot zero before any tick
    access(1'b0, 1'b0, 3'd1, 8'h00, 1'b1, 8'h00, 1'b0, "R12 sec before tick");
    readReg(8'h0A, 8'h00, "R12 status A reset");
    readReg(8'h0B, 8'h00, "R12 status B reset");
    readReg(8'h0F, 8'h00, "R12 reset code reset");

    // BCD, 12-hour: 15:37:45, weekday 3, 28th, month index 1, 2024
    setTime(45, 37, 15, 3, 28, 1, 2024);
    pulseTick();
    readReg(8'h00, toBcd(45), "R5 sec bcd");
    readReg(8'h02, toBcd(37), "R5 min bcd");
    readReg(8'h04, 8'h80 | toBcd(3), "R6 hour 12h pm bcd");
    readReg(8'h06, toBcd(4), "R7 weekday");
    readReg(8'h07, toBcd(28), "R5 mday bcd");
    readReg(8'h08, toBcd(2), "R7 month");
    readReg(8'h09, toBcd(24), "R7 year");
    readReg(8'h32, toBcd(20), "R7 century");

    // R3: input change without tick is invisible
    todSec = 6'd10;
    readReg(8'h00, toBcd(45), "R3 no tick hold");
    pulseTick();
    readReg(8'h00, toBcd(10), "R3 after tick");

    // binary, 24-hour
    writeReg(8'h0B, 8'h06, 1'b0, "R9 write B");
    readReg(8'h0B, 8'h06, "R9 B readback");
    readReg(8'h04, showField(15, 1), "R6 hour 24h bin");
    readReg(8'h00, showField(10, 1), "R5 sec binary");

    // R9: periodic enable refused
    writeReg(8'h0B, 8'h46, 1'b1, "R9 pie refused");
    readReg(8'h0B, 8'h06, "R9 B unchanged");

    // R4: halt
    writeReg(8'h0B, 8'h86, 1'b0, "R4 halt on");
    todSec = 6'd20;
    pulseTick();
    readReg(8'h00, showField(10, 1), "R4 halted hold");
    writeReg(8'h0B, 8'h06, 1'b0, "R4 halt off");
    readReg(8'h00, showField(20, 1), "R4 pending tick applied");

    // R6: 12-hour corners
    writeReg(8'h0B, 8'h04, 1'b0, "R6 12h binary");
    todHour = 5'd0; pulseTick();
    readReg(8'h04, 8'h0C, "R6 midnight as 12");
    todHour = 5'd12; pulseTick();
    readReg(8'h04, 8'h8C, "R6 noon as 12 pm");
    writeReg(8'h0B, 8'h00, 1'b0, "R6 12h bcd");
    readReg(8'h04, 8'h92, "R6 noon bcd");
    todHour = 5'd23; pulseTick();
    readReg(8'h04, 8'h91, "R6 23h bcd");

    // R7: year boundary
    todYear = YW'(1999); pulseTick();
    readReg(8'h09, 8'h99, "R7 year 99 bcd");
    readReg(8'h32, 8'h19, "R7 century 19 bcd");
    writeReg(8'h0B, 8'h04, 1'b0, "R7 binary");
    readReg(8'h09, 8'h63, "R7 year 99 binary");

    // R8: status A strip
    writeReg(8'h0A, 8'hA6, 1'b0, "R8 write A");
    readReg(8'h0A, 8'h26, "R8 A bit7 cleared");

    // R10: fixed registers
    readReg(8'h0D, 8'h80, "R10 D power good");
    readReg(8'h0C, 8'h00, "R10 C zero");
    readReg(8'h0E, 8'h00, "R10 diag zero");
    writeReg(8'h0C, 8'h55, 1'b1, "R10 write C refused");
    writeReg(8'h0D, 8'h00, 1'b1, "R10 write D refused");
    readReg(8'h0D, 8'h80, "R10 D after write");

    // R1: illegal index keeps selection (0x0D)
    access(1'b1, 1'b1, 3'd1, 8'h05, 1'b0, 8'h00, 1'b1, "R1 index 05 refused");
    access(1'b1, 1'b1, 3'd1, 8'h33, 1'b0, 8'h00, 1'b1, "R1 index 33 refused");
    access(1'b0, 1'b0, 3'd1, 8'h00, 1'b1, 8'h80, 1'b0, "R1 selection kept");
    access(1'b1, 1'b0, 3'd1, 8'h00, 1'b0, 8'h00, 1'b1, "R1 address read refused");

    // R2: size errors
    access(1'b1, 1'b1, 3'd2, 8'h0F, 1'b0, 8'h00, 1'b1, "R2 address size 2");
    access(1'b0, 1'b0, 3'd1, 8'h00, 1'b1, 8'h80, 1'b0, "R2 selection kept");
    access(1'b0, 1'b0, 3'd4, 8'h00, 1'b1, 8'h80, 1'b1, "R2 data read size 4");
    selReg(8'h0F, "R2 select reset code");
    access(1'b0, 1'b1, 3'd0, 8'h77, 1'b0, 8'h00, 1'b1, "R2 data write size 0");
    access(1'b0, 1'b0, 3'd1, 8'h00, 1'b1, 8'h00, 1'b0, "R2 write dropped");

    // R11: time writes discarded, reset code r/w
    writeReg(8'h00, 8'h55, 1'b0, "R11 sec write accepted");
    readReg(8'h00, showField(20, 1), "R11 sec unchanged");
    writeReg(8'h32, 8'h01, 1'b0, "R11 century write accepted");
    readReg(8'h32, showField(19, 1), "R11 century unchanged");
    writeReg(8'h0F, 8'h5A, 1'b0, "R11 reset code write");
    readReg(8'h0F, 8'h5A, "R11 reset code readback");

    // R13: read data holds over idle cycles
    repeat (3) @(negedge clk);
    nChecks++;
    if (busRdata !== 8'h5A || busErr !== 1'b0) begin
      nFails++;
      $display("FAIL R13: got data=%h err=%b, expected data=5a err=0", busRdata, busErr);
    end

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule